// File: doc/BRIEF.md
# Single-Cycle Pointer Array Reducer

This block builds the column-pointer array of a compressed sparse column graph from an edge list that is already sorted by destination. On each beat it receives a window of `W` destination IDs, a per-lane enable and a key. A bank of `W` comparators tests every enabled lane against the key. An adder tree sums the match bits in the same cycle. A running accumulator turns these per-vertex counts into pointer values. After a start pulse the first value is 0. After that, every beat flagged as the last one for a vertex produces the pointer of the following vertex. That pointer is the previous pointer plus the in-degree of the vertex.

The same datapath also has a reindex mode. In this mode each lane counts when its ID is strictly smaller than the query key. The counts are summed over the beats of one query. If the table of sampled IDs is sorted and unique, the result is the zero-based local index of the query. The accumulator clears after each query. There are no serial increments and no locking, so every beat costs exactly one cycle, and every result appears one cycle after the beat that completes it.

Top module: `csc_ptr_reducer`

## Requirements
- R1: After reset `res_vld_o` is 0 and the accumulator is 0. In pointer mode (`mode_i`=0), a last beat with no enabled lanes and no start emits 0.
- R2: A start pulse in pointer mode makes `res_vld_o`=1 and `res_o`=0 in the next cycle. A start pulse in reindex mode (`mode_i`=1) clears the accumulator and emits nothing.
- R3: In pointer mode a lane counts when its enable bit is set and its ID equals `key_i`. On a last beat the next cycle shows `res_vld_o`=1 and `res_o` equal to the previous pointer plus the count.
- R4: A valid beat with `beat_last_i`=0 produces no output. Its count is added to the result of the next last beat.
- R5: A vertex with zero in-degree emits a pointer equal to the previous one.
- R6: Lanes with their enable bit clear are left out of the count, whatever their ID.
- R7: In reindex mode a lane counts when it is enabled and its ID is strictly less than `key_i`. Counts are summed across the beats of one query. The last beat emits the sum and clears the accumulator for the next query.
- R8: A window in which all `W` lanes match adds exactly `W`.
- R9: A start pulse takes priority over a beat in the same cycle. That beat is dropped.
- R10: `res_vld_o` is 1 only in the cycle after a start in pointer mode or after a last beat. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new array or reindex run |
| mode_i | input | 1 | 0 = pointer build, 1 = reindex |
| beat_vld_i | input | 1 | Window on the ID lanes is valid |
| beat_last_i | input | 1 | This beat closes the current vertex or query |
| lane_en_i | input | W | Per-lane enable |
| ids_i | input | W*IDW | Lane IDs, lane l at bits [l*IDW +: IDW] |
| key_i | input | IDW | Target vertex or query ID |
| res_vld_o | output | 1 | Result valid |
| res_o | output | PTRW | Pointer value or local index |

## Verification
The bench targets several corner cases:
- A vertex spread over several beats. A design that emitted a result or lost the partial count on a non-last beat would give a short pointer.
- A zero-degree vertex. A design that skipped it would leave a gap in the array.
- A full window in which every lane matches. A count register one bit too narrow would wrap to 0.
- Masked lanes that carry matching IDs, which would inflate the count if the mask were missing.
- Reindex queries in sequence. They show whether the accumulator really clears between queries.
- The strict less-than comparison, probed with a table entry equal to the query.
- A start pulse that collides with a beat. A design that let the beat win would emit a nonzero first pointer.

// File: rtl/csc_ptr_pkg.sv
package csc_ptr_pkg;
    typedef enum logic {
        MODE_PTR  = 1'b0,
        MODE_RIDX = 1'b1
    } red_mode_e;
endpackage

// File: rtl/csc_cmp_bank.sv
module csc_cmp_bank
    import csc_ptr_pkg::*;
#(
    parameter int W   = 16,
    parameter int IDW = 16
) (
    input  logic [W*IDW-1:0] ids_i,
    input  logic [W-1:0]     en_i,
    input  logic [IDW-1:0]   key_i,
    input  red_mode_e        mode_i,
    output logic [W-1:0]     hit_o
);
    // One comparator per lane; mode picks equality or strict less-than.
    for (genvar g = 0; g < W; g++) begin : g_lane
        logic [IDW-1:0] lane_id;
        logic           cmp_hit;
        assign lane_id = ids_i[g*IDW +: IDW];
        always_comb begin
            if (mode_i == MODE_PTR) cmp_hit = (lane_id == key_i);
            else                    cmp_hit = (lane_id < key_i);
        end
        assign hit_o[g] = en_i[g] & cmp_hit;
    end
endmodule

// File: rtl/csc_adder_tree.sv
module csc_adder_tree #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] sum_o
);
    localparam int LV = (W > 1) ? $clog2(W) : 1;
    localparam int NL = 1 << LV;

    // Heap-ordered tree: leaves at NL..2*NL-1, root at index 1.
    logic [CW-1:0] node [1:2*NL-1];

    for (genvar l = 0; l < NL; l++) begin : g_leaf
        if (l < W) begin : g_real
            assign node[NL+l] = CW'(bits_i[l]);
        end else begin : g_pad
            assign node[NL+l] = '0;
        end
    end

    for (genvar n = 1; n < NL; n++) begin : g_node
        assign node[n] = node[2*n] + node[2*n+1];
    end

    assign sum_o = node[1];
endmodule

// File: rtl/csc_ptr_reducer.sv
module csc_ptr_reducer
    import csc_ptr_pkg::*;
#(
    parameter int W    = 16,
    parameter int IDW  = 16,
    parameter int PTRW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic              beat_vld_i,
    input  logic              beat_last_i,
    input  logic [W-1:0]      lane_en_i,
    input  logic [W*IDW-1:0]  ids_i,
    input  logic [IDW-1:0]    key_i,
    output logic              res_vld_o,
    output logic [PTRW-1:0]   res_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [PTRW-1:0] acc;
        logic            vld;
        logic [PTRW-1:0] res;
    } red_st_t;

    red_mode_e       mode;
    logic [W-1:0]    hit;
    logic [CW-1:0]   cnt;
    logic [PTRW-1:0] sum_ext;
    red_st_t         st_d, st_q;

    assign mode = red_mode_e'(mode_i);

    csc_cmp_bank #(.W(W), .IDW(IDW)) u_cmp (
        .ids_i  (ids_i),
        .en_i   (lane_en_i),
        .key_i  (key_i),
        .mode_i (mode),
        .hit_o  (hit)
    );

    csc_adder_tree #(.W(W), .CW(CW)) u_tree (
        .bits_i (hit),
        .sum_o  (cnt)
    );

    assign sum_ext = st_q.acc + PTRW'(cnt);

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (start_i) begin
            st_d.acc = '0;
            if (mode == MODE_PTR) begin
                st_d.vld = 1'b1;
                st_d.res = '0;
            end
        end else if (beat_vld_i) begin
            if (beat_last_i) begin
                st_d.vld = 1'b1;
                st_d.res = sum_ext;
                st_d.acc = (mode == MODE_PTR) ? sum_ext : '0;
            end else begin
                st_d.acc = sum_ext;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_vld_o = st_q.vld;
    assign res_o     = st_q.res;
endmodule

// File: rtl/csc_ptr_reducer_chk.sv
module csc_ptr_reducer_chk #(
    parameter int W    = 16,
    parameter int IDW  = 16,
    parameter int PTRW = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            mode_i,
    input logic            beat_vld_i,
    input logic            beat_last_i,
    input logic            res_vld_o,
    input logic [PTRW-1:0] res_o
);
    logic            pm_q, st_q;
    logic [PTRW-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pm_q   <= 1'b0;
            st_q   <= 1'b0;
            prev_q <= '0;
        end else begin
            pm_q <= !mode_i;
            st_q <= start_i;
            if (res_vld_o && pm_q) prev_q <= res_o;
        end
    end

    // R2
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !mode_i) |=> (res_vld_o && res_o == '0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !(beat_vld_i && beat_last_i)) |=> !res_vld_o);

    // R10
    ridx_start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i) |=> !res_vld_o);

    // R3
    ptr_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_o && pm_q && !st_q) |-> (res_o >= prev_q));
endmodule

bind csc_ptr_reducer csc_ptr_reducer_chk #(.W(W), .IDW(IDW), .PTRW(PTRW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .beat_vld_i  (beat_vld_i),
    .beat_last_i (beat_last_i),
    .res_vld_o   (res_vld_o),
    .res_o       (res_o)
);

// File: tb/sim_csc_ptr_reducer.sv
module sim_csc_ptr_reducer;
    localparam int W    = 16;
    localparam int IDW  = 16;
    localparam int PTRW = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             mode_i = 1'b0;
    logic             beat_vld_i = 1'b0;
    logic             beat_last_i = 1'b0;
    logic [W-1:0]     lane_en_i = '0;
    logic [W*IDW-1:0] ids_i = '0;
    logic [IDW-1:0]   key_i = '0;
    logic             res_vld_o;
    logic [PTRW-1:0]  res_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    int ptr_m = 0;

    always #2 clk = ~clk;

    csc_ptr_reducer #(.W(W), .IDW(IDW), .PTRW(PTRW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .beat_vld_i(beat_vld_i), .beat_last_i(beat_last_i),
        .lane_en_i(lane_en_i), .ids_i(ids_i), .key_i(key_i),
        .res_vld_o(res_vld_o), .res_o(res_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_cnt(input logic [W*IDW-1:0] ids, input logic [W-1:0] en,
                                   input logic [IDW-1:0] key, input logic md);
        int c = 0;
        for (int l = 0; l < W; l++) begin
            if (en[l]) begin
                if (!md && ids[l*IDW +: IDW] == key) c++;
                if (md && ids[l*IDW +: IDW] < key) c++;
            end
        end
        return c;
    endfunction

    // Apply one cycle of stimulus; outputs are observed at the following negedge.
    task automatic cyc(input logic st, input logic md, input logic bv, input logic bl,
                       input logic [W-1:0] en, input logic [W*IDW-1:0] ids, input logic [IDW-1:0] key);
        start_i = st; mode_i = md; beat_vld_i = bv; beat_last_i = bl;
        lane_en_i = en; ids_i = ids; key_i = key;
        @(negedge clk);
        start_i = 1'b0; beat_vld_i = 1'b0; beat_last_i = 1'b0; lane_en_i = '0;
    endtask

    function automatic logic [W*IDW-1:0] fill(input int base, input int step);
        logic [W*IDW-1:0] v;
        for (int l = 0; l < W; l++) v[l*IDW +: IDW] = IDW'(base + l*step);
        return v;
    endfunction

    task automatic t_reset;
        chk("R1 vld after reset", int'(res_vld_o), 0);
        cyc(0, 0, 1, 1, '0, '0, '0);
        chk("R1 vld empty beat", int'(res_vld_o), 1);
        chk("R1 acc zero", int'(res_o), 0);
    endtask

    task automatic t_start;
        cyc(1, 1, 0, 0, '0, '0, '0);
        chk("R2 reindex start silent", int'(res_vld_o), 0);
        cyc(1, 0, 0, 0, '0, '0, '0);
        chk("R2 start vld", int'(res_vld_o), 1);
        chk("R2 start zero", int'(res_o), 0);
        ptr_m = 0;
        cyc(0, 0, 0, 0, '0, '0, '0);
        chk("R10 idle", int'(res_vld_o), 0);
    endtask

    task automatic t_ptr;
        logic [W*IDW-1:0] ids;
        ids = fill(0, 0);
        for (int l = 3; l < W; l++) ids[l*IDW +: IDW] = 16'd1;
        cyc(0, 0, 1, 1, '1, ids, 16'd0);
        ptr_m += ref_cnt(ids, '1, 16'd0, 0);
        chk("R3 vertex0 vld", int'(res_vld_o), 1);
        chk("R3 vertex0 ptr", int'(res_o), ptr_m);
        cyc(0, 0, 1, 1, '1, ids, 16'd1);
        ptr_m += ref_cnt(ids, '1, 16'd1, 0);
        chk("R3 vertex1 ptr", int'(res_o), ptr_m);
    endtask

    task automatic t_zero;
        cyc(0, 0, 1, 1, '1, fill(100, 1), 16'd2);
        chk("R5 zero degree ptr", int'(res_o), ptr_m);
    endtask

    task automatic t_multi;
        logic [W*IDW-1:0] ids;
        ids = fill(3, 0);
        cyc(0, 0, 1, 0, '1, ids, 16'd3);
        chk("R4 non-last silent", int'(res_vld_o), 0);
        cyc(0, 0, 1, 0, 16'h00FF, ids, 16'd3);
        chk("R4 non-last silent 2", int'(res_vld_o), 0);
        cyc(0, 0, 1, 1, 16'h0003, ids, 16'd3);
        ptr_m += 16 + 8 + 2;
        chk("R4 multi-beat vld", int'(res_vld_o), 1);
        chk("R4 multi-beat ptr", int'(res_o), ptr_m);
    endtask

    task automatic t_mask;
        cyc(0, 0, 1, 1, 16'h0001, fill(4, 0), 16'd4);
        ptr_m += 1;
        chk("R6 masked lanes", int'(res_o), ptr_m);
    endtask

    task automatic t_full;
        cyc(0, 0, 1, 1, '1, fill(5, 0), 16'd5);
        ptr_m += W;
        chk("R8 full window", int'(res_o), ptr_m);
    endtask

    task automatic t_ridx;
        logic [W*IDW-1:0] a, b;
        a = fill(0, 2);   // 0,2,...,30
        b = fill(32, 2);  // 32,...,62
        cyc(1, 1, 0, 0, '0, '0, '0);
        cyc(0, 1, 1, 0, '1, a, 16'd40);
        chk("R7 partial silent", int'(res_vld_o), 0);
        cyc(0, 1, 1, 1, '1, b, 16'd40);
        chk("R7 query 40", int'(res_o), ref_cnt(a, '1, 16'd40, 1) + ref_cnt(b, '1, 16'd40, 1));
        cyc(0, 1, 1, 1, '1, a, 16'd6);
        chk("R7 strict less, cleared", int'(res_o), 3);
        cyc(0, 1, 1, 1, 16'h000F, a, 16'd30);
        chk("R7 masked query", int'(res_o), 4);
    endtask

    task automatic t_collide;
        cyc(1, 0, 1, 1, '1, fill(7, 0), 16'd7);
        chk("R9 start wins vld", int'(res_vld_o), 1);
        chk("R9 start wins val", int'(res_o), 0);
        cyc(0, 0, 1, 1, 16'h0007, fill(7, 0), 16'd7);
        chk("R9 after start", int'(res_o), 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_ptr();
        t_zero();
        t_multi();
        t_mask();
        t_full();
        t_ridx();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule